// File: doc/BRIEF.md
# Intel HEX Record Stream Loader

This block sits between a character source (a UART receiver, a boot ROM streamer or a debug port) and a byte-wide memory write port. It takes one ASCII character per accepted cycle, finds record starts, turns pairs of hex digits into bytes and writes each data byte to memory at an address that advances by one after every byte. Each record's header carries a byte count, a 16-bit load address and a type code. Only data records (type code 00) write memory. Every other type is still parsed and checked against its checksum, but it leaves memory untouched.

Each complete record is closed by an 8-bit checksum. The block keeps a running modulo-256 sum of all decoded bytes and reports the outcome as a one-cycle good or bad pulse. It also counts good and bad records. A character that is not a hex digit inside a record abandons that record and raises an error pulse. A line terminator inside a record drops the record silently. Data written before a failure is left in place.

Top module: `hex_stream_loader`

## Requirements
- R1: While waiting for a record, every character other than ':' (0x3A) is consumed and ignored: no write, no status pulse, no counter change.
- R2: After ':' the fields arrive as hex-digit pairs, with the high nibble first: count N (1 byte), load address (2 bytes, high byte first), type (1 byte), N data bytes, checksum (1 byte). Data byte k is written with data equal to its value at address load+k.
- R3: The write address is 16 bits wide and advances by one per data byte. It wraps from 0xFFFF to 0x0000.
- R4: Only type 0x00 produces writes. Records of any other type produce no write but are checksum-checked and reported like data records.
- R5: When the modulo-256 sum of count, both address bytes, type, data and checksum is zero, rec_good pulses for one cycle on the cycle after the last checksum digit is accepted, and good_count increases by one on the following cycle.
- R6: On a nonzero sum, rec_bad pulses instead and bad_count increases by one. Writes already issued for that record stand.
- R7: Digits '0'-'9', 'A'-'F' and 'a'-'f' are all accepted as nibble values 0-15.
- R8: Any other character inside a record (including ':' and space) pulses rec_err for one cycle and returns the block to waiting. Neither counter changes.
- R9: CR (0x0D) or LF (0x0A) inside a record, before its checksum is complete, drops the record with no pulse and no counter change. A line that ends before the header is complete causes no write.
- R10: in_ready equals the inverse of mem_busy. No character is consumed while mem_busy is high.
- R11: mem_wr is a single-cycle pulse. It is raised in the cycle after the low digit of a data byte is accepted.
- R12: A synchronous active-high rst clears both counters and all pulses, and returns the block to waiting for ':'.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A character is offered on in_char |
| in_char | input | 8 | ASCII character |
| in_ready | output | 1 | Block can consume a character this cycle |
| mem_busy | input | 1 | Memory port cannot take writes |
| mem_wr | output | 1 | One-cycle write strobe |
| mem_addr | output | 16 | Write address |
| mem_data | output | 8 | Write data |
| rec_good | output | 1 | Record closed with correct checksum |
| rec_bad | output | 1 | Record closed with wrong checksum |
| rec_err | output | 1 | Record abandoned on an illegal character |
| good_count | output | 16 | Number of good records since reset |
| bad_count | output | 16 | Number of bad-checksum records since reset |

## Verification
The bench drives upper-case and lower-case records, which separates digit decoding from field order. A record placed just below 0xFFFF shows whether the address wraps or carries into a wider value. A non-data type with a payload shows whether type gating is applied per record. A single corrupted checksum bit separates checksum failure from write suppression. Junk before ':', an illegal digit, and lines cut short by CR/LF test the three ways a record can fail to complete, and each one is followed by a clean record to show that the parser has resynchronised. A busy stall in the middle of a data byte shows whether characters are consumed while the memory port is blocked.

// File: rtl/hex_ldr_pkg.sv
package hex_ldr_pkg;

  typedef enum logic [2:0] {
    ST_WAIT, ST_COUNT, ST_ADDR_HI, ST_ADDR_LO, ST_TYPE, ST_DATA, ST_CSUM
  } ldr_state_t;

  typedef enum logic [1:0] {CH_OTHER, CH_HEX, CH_EOL, CH_START} char_class_t;

  localparam logic [7:0] REC_TYPE_DATA = 8'h00;

  function automatic char_class_t classify(input logic [7:0] c);
    if (c == 8'h3A) return CH_START;
    if (c == 8'h0D || c == 8'h0A) return CH_EOL;
    if ((c >= 8'h30 && c <= 8'h39) || (c >= 8'h41 && c <= 8'h46) ||
        (c >= 8'h61 && c <= 8'h66)) return CH_HEX;
    return CH_OTHER;
  endfunction

  function automatic logic [3:0] nibble_of(input logic [7:0] c);
    logic [7:0] v;
    if (c <= 8'h39)      v = c - 8'h30;
    else if (c <= 8'h46) v = c - 8'h37;
    else                 v = c - 8'h57;
    return v[3:0];
  endfunction

  function automatic logic [7:0] csum_add(input logic [7:0] s, input logic [7:0] b);
    return s + b;
  endfunction

endpackage

// File: rtl/hex_char_decode.sv
module hex_char_decode
  import hex_ldr_pkg::*;
(
  input  logic [7:0]  ch,
  output char_class_t cls,
  output logic [3:0]  nib
);
  always_comb begin
    cls = classify(ch);
    nib = (cls == CH_HEX) ? nibble_of(ch) : 4'h0;
  end
endmodule

// File: rtl/hex_record_fsm.sv
module hex_record_fsm
  import hex_ldr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  char_class_t       cls,
  input  logic [3:0]        nib,
  output logic              wr_q,
  output logic [ADDR_W-1:0] wr_addr_q,
  output logic [DATA_W-1:0] wr_data_q,
  output logic              done_q,
  output logic              ok_q,
  output logic              err_q,
  output ldr_state_t        state
);
  localparam int ADDR_BYTES = ADDR_W / 8;

  logic              hi_phase;
  logic [3:0]        hi_nib;
  logic [7:0]        left;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        rtype;
  logic [7:0]        sum;

  logic [7:0] full_byte;
  logic [7:0] sum_next;
  logic       byte_done;

  assign full_byte = {hi_nib, nib};
  assign sum_next  = csum_add(sum, full_byte);
  assign byte_done = take && (state != ST_WAIT) && (cls == CH_HEX) && hi_phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_WAIT;
      hi_phase  <= 1'b0;
      hi_nib    <= '0;
      left      <= '0;
      addr      <= '0;
      rtype     <= '0;
      sum       <= '0;
      wr_q      <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      done_q    <= 1'b0;
      ok_q      <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      wr_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (take) begin
        if (state == ST_WAIT) begin
          if (cls == CH_START) begin
            state    <= ST_COUNT;
            hi_phase <= 1'b0;
            sum      <= '0;
          end
        end else begin
          case (cls)
            CH_EOL: state <= ST_WAIT;
            CH_HEX: begin
              if (!hi_phase) begin
                hi_nib   <= nib;
                hi_phase <= 1'b1;
              end else begin
                hi_phase <= 1'b0;
                sum      <= sum_next;
                case (state)
                  ST_COUNT: begin
                    left  <= full_byte;
                    state <= ST_ADDR_HI;
                  end
                  ST_ADDR_HI: begin
                    addr[ADDR_W-1 -: 8] <= full_byte;
                    state <= (ADDR_BYTES > 1) ? ST_ADDR_LO : ST_TYPE;
                  end
                  ST_ADDR_LO: begin
                    addr[7:0] <= full_byte;
                    state     <= ST_TYPE;
                  end
                  ST_TYPE: begin
                    rtype <= full_byte;
                    state <= (left == 8'd0) ? ST_CSUM : ST_DATA;
                  end
                  ST_DATA: begin
                    if (rtype == REC_TYPE_DATA) begin
                      wr_q      <= 1'b1;
                      wr_addr_q <= addr;
                      wr_data_q <= full_byte[DATA_W-1:0];
                    end
                    addr <= addr + 1'b1;
                    left <= left - 8'd1;
                    if (left == 8'd1) state <= ST_CSUM;
                  end
                  ST_CSUM: begin
                    done_q <= 1'b1;
                    ok_q   <= (sum_next == 8'd0);
                    state  <= ST_WAIT;
                  end
                  default: state <= ST_WAIT;
                endcase
              end
            end
            default: begin
              state <= ST_WAIT;
              err_q <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  logic unused_ok;
  assign unused_ok = byte_done;
endmodule

// File: rtl/hex_status_counters.sv
module hex_status_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done,
  input  logic             ok,
  output logic [CNT_W-1:0] good_cnt,
  output logic [CNT_W-1:0] bad_cnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      good_cnt <= '0;
      bad_cnt  <= '0;
    end else if (done) begin
      if (ok) good_cnt <= good_cnt + 1'b1;
      else    bad_cnt  <= bad_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hex_stream_loader.sv
module hex_stream_loader
  import hex_ldr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_char,
  output logic              in_ready,
  input  logic              mem_busy,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              rec_good,
  output logic              rec_bad,
  output logic              rec_err,
  output logic [CNT_W-1:0]  good_count,
  output logic [CNT_W-1:0]  bad_count
);
  char_class_t cls_w;
  logic [3:0]  nib_w;
  logic        take_w;
  logic        done_w;
  logic        ok_w;
  ldr_state_t  state_w;

  assign in_ready = !mem_busy;
  assign take_w   = in_valid && in_ready;

  hex_char_decode u_dec (
    .ch  (in_char),
    .cls (cls_w),
    .nib (nib_w)
  );

  hex_record_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .take      (take_w),
    .cls       (cls_w),
    .nib       (nib_w),
    .wr_q      (mem_wr),
    .wr_addr_q (mem_addr),
    .wr_data_q (mem_data),
    .done_q    (done_w),
    .ok_q      (ok_w),
    .err_q     (rec_err),
    .state     (state_w)
  );

  hex_status_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .done     (done_w),
    .ok       (ok_w),
    .good_cnt (good_count),
    .bad_cnt  (bad_count)
  );

  assign rec_good = done_w && ok_w;
  assign rec_bad  = done_w && !ok_w;
endmodule

// File: rtl/hex_stream_loader_chk.sv
module hex_stream_loader_chk
  import hex_ldr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             mem_busy,
  input logic             mem_wr,
  input logic             rec_good,
  input logic             rec_bad,
  input logic             rec_err,
  input logic [CNT_W-1:0] good_count,
  input logic [CNT_W-1:0] bad_count,
  input ldr_state_t       state_w
);
  assert_wr_single_R11: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> !mem_wr);

  assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    mem_busy |=> !mem_wr && !rec_good && !rec_bad && !rec_err);

  assert_status_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rec_good, rec_bad, rec_err}));

  assert_good_count_R5: assert property (@(posedge clk) disable iff (rst)
    rec_good |=> good_count == $past(good_count) + 1'b1);

  assert_bad_count_R6: assert property (@(posedge clk) disable iff (rst)
    rec_bad |=> bad_count == $past(bad_count) + 1'b1);

  assert_err_no_count_R8: assert property (@(posedge clk) disable iff (rst)
    rec_err |=> $stable(good_count) && $stable(bad_count));

  assert_write_from_data_R4: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> $past(state_w) == ST_DATA);
endmodule

bind hex_stream_loader hex_stream_loader_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mem_busy   (mem_busy),
  .mem_wr     (mem_wr),
  .rec_good   (rec_good),
  .rec_bad    (rec_bad),
  .rec_err    (rec_err),
  .good_count (good_count),
  .bad_count  (bad_count),
  .state_w    (state_w)
);

// File: tb/hex_stream_loader_bench.sv
module hex_stream_loader_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_char = 8'h00;
  logic        in_ready;
  logic        mem_busy = 1'b0;
  logic        mem_wr;
  logic [15:0] mem_addr;
  logic [7:0]  mem_data;
  logic        rec_good, rec_bad, rec_err;
  logic [15:0] good_count, bad_count;

  always #5 clk = ~clk;

  hex_stream_loader u_hex_stream_loader (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_char(in_char),
    .in_ready(in_ready), .mem_busy(mem_busy), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_data(mem_data), .rec_good(rec_good),
    .rec_bad(rec_bad), .rec_err(rec_err), .good_count(good_count),
    .bad_count(bad_count)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit stall_req = 0;
  int exp_good = 0;
  int exp_bad = 0;
  logic [23:0] wr_q[$];
  int st_q[$];
  logic [7:0] pay [16];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hexch(input logic [3:0] n, input bit lower);
    if (n < 10) return 8'h30 + {4'h0, n};
    return (lower ? 8'h57 : 8'h37) + {4'h0, n};
  endfunction

  task automatic send_char(input logic [7:0] c);
    @(negedge clk);
    in_valid = 1'b1;
    in_char  = c;
    if (stall_req) begin
      stall_req = 0;
      mem_busy = 1'b1;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        check(in_ready == 1'b0, "R10 ready while busy", {31'b0, in_ready}, 32'h0);
      end
      mem_busy = 1'b0;
    end
    @(posedge clk);
    while (!in_ready) @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit lower);
    send_char(hexch(b[7:4], lower));
    send_char(hexch(b[3:0], lower));
  endtask

  // code: 1 good, 2 bad
  task automatic send_record(input int n, input logic [15:0] a, input logic [7:0] t,
                             input bit lower, input bit corrupt, input int stall_at);
    logic [7:0] s;
    s = n[7:0] + a[15:8] + a[7:0] + t;
    send_char(8'h3A);
    send_byte(n[7:0], lower);
    send_byte(a[15:8], lower);
    send_byte(a[7:0], lower);
    send_byte(t, lower);
    for (int k = 0; k < n; k++) begin
      logic [15:0] wa;
      wa = a + k[15:0];
      s = s + pay[k];
      if (t == 8'h00) wr_q.push_back({wa, pay[k]});
      if (k == stall_at) begin
        send_char(hexch(pay[k][7:4], lower));
        stall_req = 1;
        send_char(hexch(pay[k][3:0], lower));
      end else send_byte(pay[k], lower);
    end
    s = 8'h00 - s;
    if (corrupt) s = s ^ 8'h01;
    st_q.push_back(corrupt ? 2 : 1);
    send_byte(s, lower);
    send_char(8'h0D);
    send_char(8'h0A);
  endtask

  task automatic send_str(input string str);
    for (int i = 0; i < str.len(); i++) send_char(str[i]);
  endtask

  task automatic settle_and_count(input string req);
    repeat (4) @(negedge clk);
    check(good_count == exp_good[15:0], {req, " good_count"}, {16'h0, good_count}, exp_good);
    check(bad_count == exp_bad[15:0], {req, " bad_count"}, {16'h0, bad_count}, exp_bad);
    check(wr_q.size() == 0, {req, " pending writes"}, wr_q.size(), 0);
    check(st_q.size() == 0, {req, " pending status"}, st_q.size(), 0);
  endtask

  // monitor
  bit prev_wr = 0;
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (mem_wr) begin
        if (prev_wr) check(1'b0, "R11 strobe width", 2, 1);
        if (wr_q.size() == 0) check(1'b0, "R1/R4 unexpected write", {8'h0, mem_addr, mem_data}, 0);
        else begin
          logic [23:0] e;
          e = wr_q.pop_front();
          check({mem_addr, mem_data} == e, "R2/R3 write addr,data", {8'h0, mem_addr, mem_data}, {8'h0, e});
        end
      end
      prev_wr = mem_wr;
      if (rec_good || rec_bad || rec_err) begin
        int code;
        code = rec_good ? 1 : (rec_bad ? 2 : 3);
        if (st_q.size() == 0) check(1'b0, "R8/R9 unexpected status", code, 0);
        else begin
          int e;
          e = st_q.pop_front();
          check(code == e, "R5/R6/R8 status kind", code, e);
        end
        if (rec_good) exp_good++;
        if (rec_bad) exp_bad++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check(mem_wr == 0 && rec_good == 0 && rec_bad == 0 && rec_err == 0, "R12 pulses in reset",
          {mem_wr, rec_good, rec_bad, rec_err}, 0);
    check(good_count == 0 && bad_count == 0, "R12 counters in reset", {good_count, bad_count}, 0);
    rst = 1'b0;

    // R1 junk before start, then R2/R5 upper-case record
    send_str("zz 12 AB\r\n");
    pay[0] = 8'h11; pay[1] = 8'hA5; pay[2] = 8'h3C;
    send_record(3, 16'h1234, 8'h00, 0, 0, -1);
    settle_and_count("R1 R2 R5");

    // R7 lower-case digits
    pay[0] = 8'hDE; pay[1] = 8'hAD; pay[2] = 8'hBE; pay[3] = 8'hEF;
    send_record(4, 16'hABCD, 8'h00, 1, 0, -1);
    settle_and_count("R7");

    // R3 address wrap
    pay[0] = 8'h01; pay[1] = 8'h02; pay[2] = 8'h03; pay[3] = 8'h04;
    send_record(4, 16'hFFFE, 8'h00, 0, 0, -1);
    settle_and_count("R3");

    // R4 non-data type with payload: checked, no writes
    pay[0] = 8'h77; pay[1] = 8'h88;
    send_record(2, 16'h0040, 8'h04, 0, 0, -1);
    settle_and_count("R4");

    // R6 bad checksum, writes stand
    pay[0] = 8'h5A; pay[1] = 8'hC3;
    send_record(2, 16'h0100, 8'h00, 0, 1, -1);
    settle_and_count("R6");

    // R8 illegal digit aborts, then clean record
    st_q.push_back(3);
    send_str(":03002");
    send_char("G");
    send_str("0011223344\r\n");
    pay[0] = 8'h99;
    send_record(1, 16'h0200, 8'h00, 0, 0, -1);
    settle_and_count("R8");

    // R9 short lines dropped silently
    send_str(":0012\r\n");
    send_str(":02100000\n");
    pay[0] = 8'h42;
    send_record(1, 16'h0300, 8'h00, 1, 0, -1);
    settle_and_count("R9");

    // R10 stall in the middle of a data byte
    pay[0] = 8'h6E; pay[1] = 8'h81; pay[2] = 8'hF0;
    send_record(3, 16'h0400, 8'h00, 0, 0, 1);
    settle_and_count("R10");

    // R12 reset clears counters
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    exp_good = 0; exp_bad = 0;
    @(negedge clk);
    check(good_count == 0 && bad_count == 0, "R12 counters cleared", {good_count, bad_count}, 0);
    // R12 waiting for ':' after reset: hex digits alone do nothing
    send_str("0100000011EE\n");
    settle_and_count("R12");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule